// File: doc/BRIEF.md
# Dual Up/Down Timer/Counter

This block holds two independent 16-bit timer/counters behind a small register port. Each unit can step from the system clock through a power-of-two prescaler (timer use), from the rising edges of an external clock pin (counter use), or from a pair of encoder phase inputs decoded at four steps per cycle (quadrature use). A per-unit control register selects the run state, the count direction, the step source, whether the direction comes from the control bit or from a pin, a reload enable and the prescale ratio.

Each unit flags overflow (up past all-ones) and underflow (down past zero) as separate events. The events latch into a shared pending register whether or not they are masked. A shared mask register selects which pending bits drive the single registered interrupt line. Unit 0 also has a reload register. Its value replaces the count at overflow or underflow, but only while that unit is in quadrature mode with reload enabled. In every other case the count wraps modulo 2^16.

Top module: `updown_timer_pair`

## Requirements
- R1: After reset, every register reads 0 (both control words, both counts, reload, mask, pending) and `irq` is low.
- R2: Control word layout: bit 0 run, bit 1 down (1 = count down), bits 3:2 step source (00 internal, 01 external clock, 10 quadrature, 11 internal), bit 4 direction from pin, bit 5 reload enable, bits 8:6 prescale select. While run is 0 the count holds its value.
- R3: In internal mode with prescale select s, the count moves once every 2^s running clock cycles, with the first step on the 2^s-th running cycle. A select of 7 divides by 64.
- R4: Without an active reload, counting up from 0xFFFF gives 0x0000 and counting down from 0x0000 gives 0xFFFF. The two units count independently.
- R5: In external mode the count steps once per rising edge of the synchronised `pin_a` of that unit. With bit 4 clear the direction follows bit 1. With bit 4 set, a high `pin_b` counts down and a low `pin_b` counts up.
- R6: In quadrature mode the phase pair {`pin_a`,`pin_b`} moving forward through 00, 10, 11, 01, 00 adds 1 per transition, and moving backward subtracts 1 per transition. A change of both phases at once has no effect.
- R7: Unit 0 only: when the source is quadrature and reload is enabled, an overflow or underflow loads the reload register into the count. With reload enabled in any other mode, the count wraps as in R4.
- R8: Pending bits are set on the cycle of the event regardless of the mask: bit 0 unit 0 overflow, bit 1 unit 0 underflow, bit 2 unit 1 overflow, bit 3 unit 1 underflow.
- R9: Writing the pending register clears each bit that is written as 1 and leaves the other bits unchanged.
- R10: `irq` is a register that goes high one clock after any bit is set in both pending and mask, and goes low one clock after no such bit remains.
- R11: A register write to a count takes effect even if that unit counts or reloads in the same cycle.
- R12: Addresses are 0 control 0, 1 control 1, 2 count 0, 3 count 1, 4 reload, 5 mask, 6 pending, and 7 reads 0. A read returns `bus_rdata` with `bus_rvalid` high on the clock after `bus_rd`. `bus_rvalid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after bus_rd |
| pin_a | input | 2 | Per unit: external clock, or quadrature phase A |
| pin_b | input | 2 | Per unit: external direction, or quadrature phase B |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the bus never asserts `bus_wr` and `bus_rd` in the same cycle. They also assume that a prescale select only changes while the prescaler is stopped or that the change is tolerated, and that the pins are asynchronous but slow next to the clock. The stimulus writes or reads one register per task call, each on its own clock. It holds each pin level for four clocks so that the synchroniser and edge detector see every transition once. Quadrature sequences change one phase at a time, except for the single deliberate double change. Each unit is stopped before its count is read, so the expected values do not depend on how many cycles a read takes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int NUM_UNITS = 2;
  localparam int CNT_W     = 16;
  localparam int ADDR_W    = 3;
  localparam int EV_W      = 2 * NUM_UNITS;

  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_EXT  = 2'b01,
    SRC_QUAD = 2'b10,
    SRC_ALT  = 2'b11
  } src_e;

  // bit 8..6 psel, 5 reload_en, 4 dir_pin, 3..2 src, 1 down, 0 run
  typedef struct packed {
    logic [2:0] psel;
    logic       reload_en;
    logic       dir_pin;
    src_e       src;
    logic       down;
    logic       run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [ADDR_W-1:0] A_CTRL0  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT0   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT1   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd5;
  localparam logic [ADDR_W-1:0] A_PEND   = 3'd6;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] psel,
  output logic            tick
);
  localparam int MAX_SHIFT = (1 << PS_W) - 2;

  logic [MAX_SHIFT-1:0] div_q;
  logic [MAX_SHIFT-1:0] mask;
  logic [PS_W-1:0]      shift;

  always_comb begin
    shift = (int'(psel) > MAX_SHIFT) ? PS_W'(MAX_SHIFT) : psel;
    for (int i = 0; i < MAX_SHIFT; i++) mask[i] = (i < int'(shift));
  end

  // count enable only; the clock itself is never gated
  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  assign tick = run && (&(div_q | ~mask));

  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && psel != '0) |=> (!tick || !$stable(psel)));

endmodule

// File: rtl/tmr_pin_decode.sv
module tmr_pin_decode #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_a,
  input  logic pin_b,
  output logic a_rise,
  output logic b_lvl,
  output logic q_up,
  output logic q_dn
);
  logic [SYNC-1:0] sa, sb;
  logic            a_s, b_s, pa, pb;
  logic [1:0]      delta;

  function automatic logic [1:0] gray_pos(input logic [1:0] s);
    case (s)
      2'b00:   gray_pos = 2'd0;
      2'b10:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sa <= '0;
      sb <= '0;
      pa <= 1'b0;
      pb <= 1'b0;
    end else begin
      sa <= {sa[SYNC-2:0], pin_a};
      sb <= {sb[SYNC-2:0], pin_b};
      pa <= a_s;
      pb <= b_s;
    end
  end

  assign a_s    = sa[SYNC-1];
  assign b_s    = sb[SYNC-1];
  assign a_rise = a_s & ~pa;
  assign b_lvl  = b_s;
  assign delta  = gray_pos({a_s, b_s}) - gray_pos({pa, pb});
  assign q_up   = (delta == 2'd1);
  assign q_dn   = (delta == 2'd3);

  p_double_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (a_s != pa && b_s != pb) |-> !(q_up || q_dn));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CW         = 16,
  parameter bit HAS_RELOAD = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         ctrl,
  input  logic          step,
  input  logic          up,
  input  logic          wr_cnt,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] reload_val,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          udf
);
  localparam logic [CW-1:0] TOP = '1;

  logic adv, reload_act;

  assign reload_act = HAS_RELOAD && ctrl.reload_en && (ctrl.src == SRC_QUAD);
  assign adv        = ctrl.run && step && !wr_cnt;
  assign ovf        = adv && up  && (cnt == TOP);
  assign udf        = adv && !up && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (wr_cnt) cnt <= wdata;
    else if (adv) begin
      if ((ovf || udf) && reload_act) cnt <= reload_val;
      else if (up)                    cnt <= cnt + 1'b1;
      else                            cnt <= cnt - 1'b1;
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.run && !wr_cnt) |=> $stable(cnt));
  p_wr_wins_r11: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> (cnt == $past(wdata)));
  p_reload_r7: assert property (@(posedge clk) disable iff (rst)
    ((ovf || udf) && reload_act) |=> (cnt == $past(reload_val)));
  p_wrap_up_r4: assert property (@(posedge clk) disable iff (rst)
    (ovf && !reload_act) |=> (cnt == '0));

endmodule

// File: rtl/updown_timer_pair.sv
module updown_timer_pair
  import tmr_pkg::*;
#(
  parameter int PS_W = 3,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [CNT_W-1:0]     bus_wdata,
  output logic [CNT_W-1:0]     bus_rdata,
  output logic                 bus_rvalid,
  input  logic [NUM_UNITS-1:0] pin_a,
  input  logic [NUM_UNITS-1:0] pin_b,
  output logic                 irq
);
  ctrl_t            ctrl_q [NUM_UNITS];
  logic [CNT_W-1:0] cnt    [NUM_UNITS];
  logic [CNT_W-1:0] reload_q;
  logic [EV_W-1:0]  mask_q, pend_q, ev, clr;

  // per-unit stepping
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic tick, a_rise, b_lvl, q_up, q_dn, step, up, wr_c, wr_k;

    assign wr_c = bus_wr && (bus_addr == A_CTRL0 + ADDR_W'(u));
    assign wr_k = bus_wr && (bus_addr == A_CNT0  + ADDR_W'(u));

    always_ff @(posedge clk) begin
      if (rst)       ctrl_q[u] <= '0;
      else if (wr_c) ctrl_q[u] <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    tmr_prescaler #(.PS_W(PS_W)) u_pre (
      .clk (clk),
      .rst (rst),
      .run (ctrl_q[u].run && (ctrl_q[u].src == SRC_INT || ctrl_q[u].src == SRC_ALT)),
      .psel(ctrl_q[u].psel),
      .tick(tick)
    );

    tmr_pin_decode #(.SYNC(SYNC)) u_pins (
      .clk   (clk),
      .rst   (rst),
      .pin_a (pin_a[u]),
      .pin_b (pin_b[u]),
      .a_rise(a_rise),
      .b_lvl (b_lvl),
      .q_up  (q_up),
      .q_dn  (q_dn)
    );

    always_comb begin
      unique case (ctrl_q[u].src)
        SRC_EXT: begin
          step = a_rise;
          up   = ctrl_q[u].dir_pin ? !b_lvl : !ctrl_q[u].down;
        end
        SRC_QUAD: begin
          step = q_up || q_dn;
          up   = q_up;
        end
        default: begin
          step = tick;
          up   = !ctrl_q[u].down;
        end
      endcase
    end

    tmr_counter #(.CW(CNT_W), .HAS_RELOAD(u == 0)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .ctrl      (ctrl_q[u]),
      .step      (step),
      .up        (up),
      .wr_cnt    (wr_k),
      .wdata     (bus_wdata),
      .reload_val(reload_q),
      .cnt       (cnt[u]),
      .ovf       (ev[2*u]),
      .udf       (ev[2*u+1])
    );
  end

  // shared registers: reload, mask, pending (set beats clear), irq, read port
  assign clr = (bus_wr && bus_addr == A_PEND) ? bus_wdata[EV_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q   <= '0;
      mask_q     <= '0;
      pend_q     <= '0;
      irq        <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_RELOAD) reload_q <= bus_wdata;
      if (bus_wr && bus_addr == A_MASK)   mask_q   <= bus_wdata[EV_W-1:0];
      pend_q     <= (pend_q & ~clr) | ev;
      irq        <= |(pend_q & mask_q);
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        unique case (bus_addr)
          A_CTRL0:  bus_rdata <= CNT_W'(ctrl_q[0]);
          A_CTRL1:  bus_rdata <= CNT_W'(ctrl_q[1]);
          A_CNT0:   bus_rdata <= cnt[0];
          A_CNT1:   bus_rdata <= cnt[1];
          A_RELOAD: bus_rdata <= reload_q;
          A_MASK:   bus_rdata <= CNT_W'(mask_q);
          A_PEND:   bus_rdata <= CNT_W'(pend_q);
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end

  p_pend_set_r8: assert property (@(posedge clk) disable iff (rst)
    (ev != '0) |=> ((pend_q & $past(ev)) == $past(ev)));
  p_irq_on_r10: assert property (@(posedge clk) disable iff (rst)
    (|(pend_q & mask_q)) |=> irq);
  p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
    !(|(pend_q & mask_q)) |=> !irq);
  p_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

endmodule

// File: tb/updown_timer_pair_tb.sv
`timescale 1ns/1ps
module updown_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  pin_a = '0, pin_b = '0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  updown_timer_pair u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_a(pin_a), .pin_b(pin_b), .irq(irq)
  );

  // all tasks start and end at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: pushes the expectation, monitor compares on bus_rvalid
  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk1(input logic act, input logic e, input string tag);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, e);
    end
  endtask

  task automatic pins(input int u, input logic a, input logic b);
    pin_a[u] = a; pin_b[u] = b;
    idle(4);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R12: unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk1(irq, 1'b0, "R1 irq");
    rd(3'd0, 16'h0000, "R1 ctrl0");
    rd(3'd2, 16'h0000, "R1 cnt0");
    rd(3'd3, 16'h0000, "R1 cnt1");
    rd(3'd4, 16'h0000, "R1 reload");
    rd(3'd5, 16'h0000, "R1 mask");
    rd(3'd6, 16'h0000, "R1 pend");

    // R2: 10 running edges, then hold while stopped
    wr(3'd0, 16'h0001); idle(9); wr(3'd0, 16'h0000);
    rd(3'd2, 16'd10, "R2 count while running");
    idle(5);
    rd(3'd2, 16'd10, "R2 hold while stopped");

    // R3: divide by 4 over 20 edges, select 7 divides by 64 over 128 edges
    wr(3'd2, 16'h0000); wr(3'd0, 16'h0081); idle(19); wr(3'd0, 16'h0000);
    rd(3'd2, 16'd5, "R3 div4");
    wr(3'd2, 16'h0000); wr(3'd0, 16'h01C1); idle(127); wr(3'd0, 16'h0000);
    rd(3'd2, 16'd2, "R3 sel7 div64");

    // R4/R8: unit 1 underflow wrap, unit 0 untouched
    wr(3'd3, 16'h0001); wr(3'd1, 16'h0003); idle(2); wr(3'd1, 16'h0000);
    rd(3'd3, 16'hFFFE, "R4 down wrap");
    rd(3'd2, 16'd2, "R4 independent unit");
    rd(3'd6, 16'h0008, "R8 unit1 underflow bit");

    // R4/R7: reload enabled but internal source wraps freely
    wr(3'd4, 16'h1234); wr(3'd2, 16'hFFFE); wr(3'd0, 16'h0021); idle(2); wr(3'd0, 16'h0000);
    rd(3'd2, 16'h0001, "R7 no reload outside quadrature");
    rd(3'd6, 16'h0009, "R8 unit0 overflow bit");

    // R9/R10
    wr(3'd6, 16'h0001);
    rd(3'd6, 16'h0008, "R9 write-one-clear");
    chk1(irq, 1'b0, "R10 masked pending");
    wr(3'd5, 16'h0008); idle(1);
    chk1(irq, 1'b1, "R10 unmasked pending");
    wr(3'd6, 16'h0008); idle(1);
    chk1(irq, 1'b0, "R10 cleared pending");
    wr(3'd5, 16'h0000);

    // R5: external clock, direction by bit then by pin
    wr(3'd2, 16'h0000); wr(3'd0, 16'h0005);
    for (int i = 0; i < 3; i++) begin pins(0, 1'b1, 1'b0); pins(0, 1'b0, 1'b0); end
    wr(3'd0, 16'h0000);
    rd(3'd2, 16'd3, "R5 external rising edges");
    wr(3'd0, 16'h0015);
    pins(0, 1'b0, 1'b1);
    for (int i = 0; i < 2; i++) begin pins(0, 1'b1, 1'b1); pins(0, 1'b0, 1'b1); end
    pins(0, 1'b0, 1'b0);
    pins(0, 1'b1, 1'b0); pins(0, 1'b0, 1'b0);
    wr(3'd0, 16'h0000);
    rd(3'd2, 16'd2, "R5 direction from pin");

    // R6: quadrature on unit 1
    wr(3'd3, 16'h0010); wr(3'd1, 16'h0009);
    pins(1, 1'b1, 1'b0); pins(1, 1'b1, 1'b1); pins(1, 1'b0, 1'b1); pins(1, 1'b0, 1'b0);
    pins(1, 1'b0, 1'b1); pins(1, 1'b1, 1'b1);
    pins(1, 1'b0, 1'b0);
    pins(1, 1'b1, 1'b0);
    wr(3'd1, 16'h0000);
    rd(3'd3, 16'h0013, "R6 quadrature steps and ignored double change");

    // R7: quadrature reload on unit 0
    wr(3'd6, 16'h000F);
    wr(3'd2, 16'hFFFF); wr(3'd0, 16'h0029);
    pins(0, 1'b1, 1'b0);
    wr(3'd2, 16'h0000);
    pins(0, 1'b0, 1'b0);
    wr(3'd0, 16'h0000);
    rd(3'd2, 16'h1234, "R7 reload on overflow and underflow");
    rd(3'd6, 16'h0003, "R8 both unit0 events");

    // R11: write during counting wins
    wr(3'd0, 16'h0001); wr(3'd2, 16'd100); wr(3'd0, 16'h0000);
    rd(3'd2, 16'd101, "R11 write priority");

    // R12: map and read timing
    wr(3'd1, 16'h01C9);
    rd(3'd1, 16'h01C9, "R12 control readback");
    wr(3'd1, 16'h0000);
    rd(3'd7, 16'h0000, "R12 unused address");
    idle(1);
    chk1(bus_rvalid, 1'b0, "R12 rvalid idle");

    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R12: pending reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule